// File: doc/BRIEF.md
# Reset and Exception Vector Sequencer

This block steers a 32-bit processor into reset or exception handling. It works out where each handler's vector word sits in memory, fetches that word over a simple read port with a ready handshake, and loads the result into the architectural registers that the rest of the core uses. A reset reads two words from fixed addresses: first the start address, which goes to the program counter, then the initial stack pointer. It then puts the control state into a known condition. An ordinary exception reads one word, found relative to the vector base register, and only the program counter changes.

There are two reset flavours. A power-on request reads vector slots 0 and 1 and also sets the floating-point status/control word to 0x00040001. A manual request reads slots 2 and 3 and leaves that word as it was. A reset request is a level. The block waits while the level is high and starts its fetches when the level drops. This means a reset that arrives during a sequence abandons that sequence and starts again from the first fetch.

States: `ST_IDLE` (waiting), `ST_HOLD` (a reset request is high), `ST_FETCH_PC` (first reset read), `ST_FETCH_SP` (second reset read), `ST_FETCH_EXC` (single exception read), `ST_DONE` (one-cycle completion). Transitions:
- Any state goes to `ST_HOLD` whenever a reset request is high.
- `ST_HOLD` goes to `ST_FETCH_PC` on release.
- `ST_FETCH_PC` goes to `ST_FETCH_SP` on ready.
- `ST_FETCH_SP` goes to `ST_DONE` on ready.
- `ST_IDLE` goes to `ST_FETCH_EXC` on an exception request.
- `ST_FETCH_EXC` goes to `ST_DONE` on ready.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `vec_seq_top`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first load, `pc_out`, `sp_out`, `vbr_out` and `fpscr_out` read 0, `imask_out` reads 0, `bo_out`, `cs_out` and `bank_out` read 0, and `rd_req` and `done` are low.
- R2: After a power-on request is released, the block reads byte address 0 and then byte address 4 (vector number times 4, with no base added). The word from address 0 goes to `pc_out` and the word from address 4 goes to `sp_out`.
- R3: After a manual request is released, the block reads byte address 8 and then byte address 12. The first word goes to `pc_out` and the second goes to `sp_out`.
- R4: An exception request accepted in `ST_IDLE` captures `exc_vec` and `vbr_in` in that cycle. The block then makes exactly one read, at `vbr + exc_vec*4` (modulo 2^32), and loads the word into `pc_out`. `sp_out`, `vbr_out`, `imask_out` and `fpscr_out` stay unchanged.
- R5: When a reset sequence completes, `vbr_out` is 0, `imask_out` is 4'hF, and `bo_out`, `cs_out` and `bank_out` are 0.
- R6: A completed power-on sequence sets `fpscr_out` to 32'h00040001. A completed manual sequence leaves `fpscr_out` unchanged.
- R7: `rd_req` and `rd_addr` stay constant from one cycle to the next while `rd_ready` is low, unless a reset request is high. Read data is taken in the cycle in which `rd_req` and `rd_ready` are both high.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the clock edge on which the final read of the sequence is accepted.
- R9: A reset request wins over an exception request raised in the same cycle, and that exception is dropped. An exception request raised while a sequence is running is ignored.
- R10: If power-on and manual requests are both high, the power-on sequence runs.
- R11: A reset request that arrives while a sequence is running cancels it, including any load that was due in that cycle. After release, the new sequence starts again from its first fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_req | input | 1 | Power-on reset request (level) |
| mrst_req | input | 1 | Manual reset request (level) |
| exc_req | input | 1 | Exception request |
| exc_vec | input | 8 | Exception vector number |
| vbr_in | input | 32 | Current vector base |
| rd_ready | input | 1 | Read data valid / read accepted |
| rd_data | input | 32 | Read data |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| pc_out | output | 32 | Loaded program counter |
| sp_out | output | 32 | Loaded stack pointer |
| vbr_out | output | 32 | Vector base register value |
| imask_out | output | 4 | Interrupt mask field |
| bo_out | output | 1 | Status flag cleared by reset |
| cs_out | output | 1 | Status flag cleared by reset |
| bank_out | output | 1 | Register-bank number bit |
| fpscr_out | output | 32 | FPU status/control value |
| done | output | 1 | One-cycle completion strobe |

## Verification
Two events can land in the same cycle. The first is a reset request arriving in the same cycle as an exception request. The second is a reset request arriving in the same cycle as the memory's ready, which would otherwise commit a load. The bench raises the reset together with an exception pulse and checks that only the reset's addresses are read. It also raises a manual request in the cycle where the power-on sequence's first read completes. There it checks that the cancelled power-on work leaves no trace: the floating-point word keeps its value and the restarted fetches read addresses 8 and 12.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_FETCH_PC,
        ST_FETCH_SP,
        ST_FETCH_EXC,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/vec_seq_fsm.sv
module vec_seq_fsm
    import vec_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_req,
    input  logic       mrst_req,
    input  logic       exc_req,
    input  logic       rd_ready,
    output seq_state_e state,
    output logic       is_por,
    output logic       ld_pc,
    output logic       ld_ctl,
    output logic       accept_exc,
    output logic       rd_req,
    output logic       done
);

    seq_state_e state_nx;
    logic       any_rst;

    assign any_rst = por_req | mrst_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            is_por <= 1'b0;
        end else begin
            state <= state_nx;
            if (any_rst)
                is_por <= por_req | ((state == ST_HOLD) & is_por);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (any_rst) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state)
                ST_IDLE:      if (exc_req) state_nx = ST_FETCH_EXC;
                ST_HOLD:      state_nx = ST_FETCH_PC;
                ST_FETCH_PC:  if (rd_ready) state_nx = ST_FETCH_SP;
                ST_FETCH_SP:  if (rd_ready) state_nx = ST_DONE;
                ST_FETCH_EXC: if (rd_ready) state_nx = ST_DONE;
                ST_DONE:      state_nx = ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req     = 1'b0;
        ld_pc      = 1'b0;
        ld_ctl     = 1'b0;
        accept_exc = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:      accept_exc = exc_req & ~any_rst;
            ST_HOLD:      ;
            ST_FETCH_PC: begin
                rd_req = 1'b1;
                ld_pc  = rd_ready & ~any_rst;
            end
            ST_FETCH_SP: begin
                rd_req = 1'b1;
                ld_ctl = rd_ready & ~any_rst;
            end
            ST_FETCH_EXC: begin
                rd_req = 1'b1;
                ld_pc  = rd_ready & ~any_rst;
            end
            ST_DONE:      done = 1'b1;
            default:      ;
        endcase
    end

    // R9 R10 R11
    // any reset request sends the machine to the hold state
    rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req | mrst_req) |=> (state == ST_HOLD));

    // R8
    // done lasts a single cycle
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    // never two loads at once
    one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_pc, ld_ctl, accept_exc}));

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vec_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VEC_W     = 8,
    parameter int POR_SLOT  = 0,
    parameter int MRST_SLOT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              is_por,
    input  logic              accept_exc,
    input  logic [VEC_W-1:0]  exc_vec,
    input  logic [ADDR_W-1:0] vbr_in,
    input  logic              rd_req,
    input  logic              rd_ready,
    input  logic              any_rst,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int WORD_SH = 2;
    localparam logic [ADDR_W-1:0] POR_PC_A  = ADDR_W'(POR_SLOT) << WORD_SH;
    localparam logic [ADDR_W-1:0] POR_SP_A  = ADDR_W'(POR_SLOT + 1) << WORD_SH;
    localparam logic [ADDR_W-1:0] MRST_PC_A = ADDR_W'(MRST_SLOT) << WORD_SH;
    localparam logic [ADDR_W-1:0] MRST_SP_A = ADDR_W'(MRST_SLOT + 1) << WORD_SH;

    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            base_q <= '0;
        end else if (accept_exc) begin
            vec_q  <= exc_vec;
            base_q <= vbr_in;
        end
    end

    always_comb begin
        unique case (state)
            ST_FETCH_PC:  rd_addr = is_por ? POR_PC_A : MRST_PC_A;
            ST_FETCH_SP:  rd_addr = is_por ? POR_SP_A : MRST_SP_A;
            ST_FETCH_EXC: rd_addr = base_q + (ADDR_W'(vec_q) << WORD_SH);
            default:      rd_addr = '0;
        endcase
    end

    // R7
    // address holds while a read waits
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready && !any_rst) |=> (rd_req && $stable(rd_addr)));

endmodule

// File: rtl/vec_load_regs.sv
module vec_load_regs #(
    parameter int                DATA_W     = 32,
    parameter int                IMASK_W    = 4,
    parameter logic [DATA_W-1:0] FPSCR_INIT = 32'h0004_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_pc,
    input  logic               ld_ctl,
    input  logic               is_por,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  pc_q,
    output logic [DATA_W-1:0]  sp_q,
    output logic [DATA_W-1:0]  vbr_q,
    output logic [IMASK_W-1:0] imask_q,
    output logic               bo_q,
    output logic               cs_q,
    output logic               bank_q,
    output logic [DATA_W-1:0]  fpscr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            sp_q    <= '0;
            vbr_q   <= '0;
            imask_q <= '0;
            bo_q    <= 1'b0;
            cs_q    <= 1'b0;
            bank_q  <= 1'b0;
            fpscr_q <= '0;
        end else begin
            if (ld_pc)
                pc_q <= rd_data;
            if (ld_ctl) begin
                sp_q    <= rd_data;
                vbr_q   <= '0;
                imask_q <= '1;
                bo_q    <= 1'b0;
                cs_q    <= 1'b0;
                bank_q  <= 1'b0;
                if (is_por)
                    fpscr_q <= FPSCR_INIT;
            end
        end
    end

    // R5
    // control state settles after the stack pointer load
    ctl_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ctl |=> (vbr_q == '0 && imask_q == '1 && !bo_q && !cs_q && !bank_q));

endmodule

// File: rtl/vec_seq_top.sv
module vec_seq_top
    import vec_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VEC_W   = 8,
    parameter int IMASK_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_req,
    input  logic               mrst_req,
    input  logic               exc_req,
    input  logic [VEC_W-1:0]   exc_vec,
    input  logic [DATA_W-1:0]  vbr_in,
    input  logic               rd_ready,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               rd_req,
    output logic [DATA_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  pc_out,
    output logic [DATA_W-1:0]  sp_out,
    output logic [DATA_W-1:0]  vbr_out,
    output logic [IMASK_W-1:0] imask_out,
    output logic               bo_out,
    output logic               cs_out,
    output logic               bank_out,
    output logic [DATA_W-1:0]  fpscr_out,
    output logic               done
);

    seq_state_e state;
    logic       is_por, ld_pc, ld_ctl, accept_exc;

    vec_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .mrst_req(mrst_req),
        .exc_req(exc_req), .rd_ready(rd_ready), .state(state), .is_por(is_por),
        .ld_pc(ld_pc), .ld_ctl(ld_ctl), .accept_exc(accept_exc),
        .rd_req(rd_req), .done(done)
    );

    vec_addr_gen #(.ADDR_W(DATA_W), .VEC_W(VEC_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .state(state), .is_por(is_por),
        .accept_exc(accept_exc), .exc_vec(exc_vec), .vbr_in(vbr_in),
        .rd_req(rd_req), .rd_ready(rd_ready), .any_rst(por_req | mrst_req),
        .rd_addr(rd_addr)
    );

    vec_load_regs #(.DATA_W(DATA_W), .IMASK_W(IMASK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ld_pc(ld_pc), .ld_ctl(ld_ctl),
        .is_por(is_por), .rd_data(rd_data), .pc_q(pc_out), .sp_q(sp_out),
        .vbr_q(vbr_out), .imask_q(imask_out), .bo_q(bo_out), .cs_q(cs_out),
        .bank_q(bank_out), .fpscr_q(fpscr_out)
    );

    // R4
    // the exception path never touches the stack pointer
    exc_keeps_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_EXC) |=> $stable(sp_out));

    // R6
    // a manual sequence leaves the FPU word alone
    mrst_keeps_fpscr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ctl && !is_por) |=> $stable(fpscr_out));

endmodule

// File: tb/vec_seq_top_tb.sv
module vec_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_req = 1'b0, mrst_req = 1'b0, exc_req = 1'b0;
    logic [7:0]  exc_vec = '0;
    logic [31:0] vbr_in = '0;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data;
    logic        rd_req;
    logic [31:0] rd_addr, pc_out, sp_out, vbr_out, fpscr_out;
    logic [3:0]  imask_out;
    logic        bo_out, cs_out, bank_out, done;

    int checks = 0, errors = 0;
    int cyc = 0;
    int last_acc = 0;
    int log_n = 0;
    logic [31:0] log_a [0:7];
    bit stall_en = 1'b1;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [31:0] e_pc = 0, e_sp = 0, e_vbr = 0, e_fp = 0;
    logic [3:0]  e_im = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_f(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]} ^ {a[31:16], 16'h0};
    endfunction

    assign rd_data = mem_f(rd_addr);

    vec_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .mrst_req(mrst_req),
        .exc_req(exc_req), .exc_vec(exc_vec), .vbr_in(vbr_in),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_req(rd_req),
        .rd_addr(rd_addr), .pc_out(pc_out), .sp_out(sp_out),
        .vbr_out(vbr_out), .imask_out(imask_out), .bo_out(bo_out),
        .cs_out(cs_out), .bank_out(bank_out), .fpscr_out(fpscr_out),
        .done(done)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        rd_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read log and R7 hold check
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req && prev_wait) check("R7 addr held", rd_addr, prev_addr);
            if (rd_req && rd_ready && log_n < 8) begin
                log_a[log_n] = rd_addr;
                log_n = log_n + 1;
                last_acc = cyc;
            end
            prev_wait = rd_req && !rd_ready && !por_req && !mrst_req;
            prev_addr = rd_addr;
        end
    end

    task automatic wait_done(input string req);
        bit got = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
        check({req, " R8 done seen"}, 32'(got), 32'd1);
        check({req, " R8 done timing"}, 32'(cyc), 32'(last_acc + 1));
        @(negedge clk);
        check({req, " R8 done single"}, 32'(done), 32'd0);
    endtask

    task automatic check_regs(input string req);
        check({req, " pc"}, pc_out, e_pc);
        check({req, " sp"}, sp_out, e_sp);
        check({req, " R5 vbr"}, vbr_out, e_vbr);
        check({req, " R5 imask"}, 32'(imask_out), 32'(e_im));
        check({req, " R5 flags"}, {29'd0, bo_out, cs_out, bank_out}, 32'd0);
        check({req, " R6 fpscr"}, fpscr_out, e_fp);
    endtask

    // por_v/mrst_v levels held for hold_n cycles; optional exception in the first cycle
    task automatic do_reset(input bit por_v, input bit mrst_v, input int hold_n,
                            input bit with_exc, input string req);
        logic [31:0] base;
        @(negedge clk);
        por_req = por_v; mrst_req = mrst_v; exc_req = with_exc;
        exc_vec = 8'h33; vbr_in = 32'h1000_0000;
        @(negedge clk);
        exc_req = 1'b0;
        for (int i = 1; i < hold_n; i++) @(negedge clk);
        log_n = 0;
        por_req = 1'b0; mrst_req = 1'b0;
        wait_done(req);
        base = por_v ? 32'd0 : 32'd8;
        check({req, " n reads"}, 32'(log_n), 32'd2);
        check({req, " first addr"}, log_a[0], base);
        check({req, " second addr"}, log_a[1], base + 32'd4);
        e_pc = mem_f(base); e_sp = mem_f(base + 4); e_vbr = 0; e_im = 4'hF;
        if (por_v) e_fp = 32'h0004_0001;
        check_regs(req);
    endtask

    task automatic do_exc(input logic [7:0] v, input logic [31:0] b, input string req);
        logic [31:0] ea;
        @(negedge clk);
        exc_req = 1'b1; exc_vec = v; vbr_in = b; log_n = 0;
        @(negedge clk);
        exc_req = 1'b0; exc_vec = ~v; vbr_in = ~b;
        wait_done(req);
        ea = b + {22'd0, v, 2'b00};
        check({req, " R4 n reads"}, 32'(log_n), 32'd1);
        check({req, " R4 addr"}, log_a[0], ea);
        e_pc = mem_f(ea);
        check_regs({req, " R4"});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 pc", pc_out, 0); check("R1 sp", sp_out, 0);
        check("R1 vbr", vbr_out, 0); check("R1 fpscr", fpscr_out, 0);
        check("R1 imask", 32'(imask_out), 0);
        check("R1 flags", {29'd0, bo_out, cs_out, bank_out}, 0);
        check("R1 req/done", {30'd0, rd_req, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // manual first: FPU word must stay at its register-reset value
        do_reset(1'b0, 1'b1, 2, 1'b0, "R3 R6 manual");
        do_reset(1'b1, 1'b0, 3, 1'b0, "R2 R6 power-on");
        do_reset(1'b1, 1'b1, 2, 1'b0, "R10 both");
        do_reset(1'b0, 1'b1, 1, 1'b1, "R9 reset+exc");
        do_exc(8'hFF, 32'hFFFF_FFF0, "R4 wrap");
        do_exc(8'h00, 32'h0000_0400, "R4 vec0");

        // R11: manual request cancels power-on at its first accepted read
        @(negedge clk);
        e_fp = fpscr_out;
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0; log_n = 0;
        for (int i = 0; i < 50 && log_n == 0; i++) @(negedge clk);
        mrst_req = 1'b1;
        @(negedge clk);
        log_n = 0; mrst_req = 1'b0;
        wait_done("R11 abort");
        check("R11 first addr", log_a[0], 32'd8);
        check("R11 second addr", log_a[1], 32'd12);
        e_pc = mem_f(8); e_sp = mem_f(12); e_vbr = 0; e_im = 4'hF;
        check_regs("R11 R6 abort");

        // R9: exception during a running sequence is ignored
        @(negedge clk);
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0; log_n = 0;
        @(negedge clk);
        exc_req = 1'b1; exc_vec = 8'h10; vbr_in = 32'h8000;
        @(negedge clk);
        exc_req = 1'b0;
        wait_done("R9 busy");
        repeat (4) @(negedge clk);
        check("R9 no extra read", 32'(log_n), 32'd2);
        e_pc = mem_f(0); e_sp = mem_f(4); e_fp = 32'h0004_0001;
        check_regs("R9 busy");

        // random mix
        for (int k = 0; k < 40; k++) begin
            int op = $urandom % 4;
            stall_en = (($urandom % 4) != 0);
            if (op == 0) do_reset(1'b1, 1'b0, 1 + ($urandom % 3), 1'b0, "R2 rnd");
            else if (op == 1) do_reset(1'b0, 1'b1, 1 + ($urandom % 3), 1'b0, "R3 rnd");
            else do_exc(8'($urandom), $urandom & 32'hFFFF_FFFC, "R4 rnd");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule